// File: doc/BRIEF.md
# Die-to-Die Lane Gearbox

This block is the adapter datapath between a wide core-side bus and a row of double-rate pad lanes. On the transmit side it captures a group of four 80-bit words once per core cycle. A tree of 2:1 selectors then hands out one word per fast cycle, in order from word 0 to word 3. Each word is split across the lanes: the low 40 bits go to the rising-edge slot (data0) and the high 40 bits go to the falling-edge slot (data1).

The receive side does the reverse. A frame-start strobe marks the first slot of word 0. A decoder steers each incoming slot into its word register. When the group is complete, the block presents all four words with a one-cycle valid.

The design is modelled on a single fast clock. An internal phase counter defines the core cycle. In the default double-rate mode a core cycle is four fast cycles. A single-rate mode uses only data0 and needs two fast cycles per word, so a group takes eight fast cycles. The block tells the core when it captures a group through a load strobe. A transmit frame marker travels with the lanes so that a far-end receiver can align.

Top module: `gbx_d2d_gearbox`

## Requirements
- R1: During and directly after reset, tx_d0, tx_d1, tx_frame and rx_valid are all zero. tx_load is high in the first cycle after reset is released.
- R2: tx_load is high for one cycle in every group period. The period is 4 fast cycles when sdr_mode is 0 and 8 fast cycles when sdr_mode is 1.
- R3: The tx_words value present with tx_valid high in a tx_load cycle is sent. Word k occupies tx_words[80k+79:80k]. Words go out in the order 0, 1, 2, 3, and the first slot of word 0 appears on the lanes in the cycle after the tx_load cycle.
- R4: In double-rate mode (sdr_mode 0), each fast cycle carries one whole word: tx_d0 carries bits [39:0] and tx_d1 carries bits [79:40].
- R5: In single-rate mode (sdr_mode 1), each word takes two fast cycles. tx_d0 carries bits [39:0] first and then bits [79:40]. tx_d1 stays zero.
- R6: tx_frame is high exactly in the cycle that carries the first slot of word 0 of a valid group. It is low in every other cycle.
- R7: A group whose tx_load cycle has tx_valid low drives zeros on both lane buses for its whole period and raises no tx_frame.
- R8: rx_frame high marks the sampled slot as slot 0 of word 0. After 4 slots (double-rate) or 8 slots (single-rate), in the same slot order and lane mapping as the transmit side, rx_valid is high for one cycle with the rebuilt group on rx_words. This happens in the cycle after the last slot is sampled.
- R9: rx_frame high while a group is still being assembled discards the partial group, and that sample becomes slot 0 of a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdr_mode | input | 1 | 0 selects double-rate lanes, 1 selects single-rate (data0 only) |
| tx_valid | input | 1 | Group on tx_words is valid; sampled in the tx_load cycle |
| tx_words | input | 320 | Four 80-bit transmit words, word k at [80k+79:80k] |
| tx_load | output | 1 | Capture strobe, high once per group period |
| tx_d0 | output | 40 | Rising-edge slot of each transmit lane |
| tx_d1 | output | 40 | Falling-edge slot of each transmit lane |
| tx_frame | output | 1 | Marks the first slot of word 0 on the transmit lanes |
| rx_d0 | input | 40 | Rising-edge slot of each receive lane |
| rx_d1 | input | 40 | Falling-edge slot of each receive lane |
| rx_frame | input | 1 | Marks slot 0 of a received group |
| rx_valid | output | 1 | One-cycle strobe, rebuilt group on rx_words |
| rx_words | output | 320 | Four rebuilt 80-bit words |

## Verification
A phase counter that has slipped shows up within one group period: tx_load no longer comes at the 4- or 8-cycle spacing, and the lane contents no longer follow the word order that was loaded. A wrong selector or lane-map path corrupts the slot values on tx_d0/tx_d1 in the very cycle the faulty word goes out. A receive slot counter or decoder fault shows up in the rebuilt group at the next rx_valid. A stale accumulator left after realignment also shows up there, either as mismatching words or as an extra or missing strobe. The bench ties the transmit lanes back to the receive lanes and compares each rebuilt group against a queue of the groups that were sent.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

   typedef enum logic {
      GBX_RATE_DOUBLE = 1'b0,
      GBX_RATE_SINGLE = 1'b1
   } gbx_rate_e;

   // number of lane slots in one group for a given rate
   function automatic int unsigned gbx_slots(input gbx_rate_e rate, input int unsigned group);
      return (rate == GBX_RATE_SINGLE) ? 2 * group : group;
   endfunction

endpackage

// File: rtl/gbx_phase_ctr.sv
module gbx_phase_ctr #(
   parameter int unsigned NSTAGE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdr_mode,
   output logic [NSTAGE:0]   slot,
   output logic              load
);
   import gbx_pkg::*;

   localparam int unsigned GROUP = 1 << NSTAGE;
   localparam int unsigned SW    = NSTAGE + 1;

   logic [SW-1:0] cnt_q;
   logic [SW-1:0] last_slot;
   gbx_rate_e     rate;

   assign rate      = gbx_rate_e'(sdr_mode);
   assign last_slot = SW'(gbx_slots(rate, GROUP) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q >= last_slot)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign slot = cnt_q;
   assign load = rst_n && (cnt_q == '0);

   // R2
   load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);

endmodule

// File: rtl/gbx_mux_tree.sv
module gbx_mux_tree #(
   parameter int unsigned W      = 80,
   parameter int unsigned NSTAGE = 2
) (
   input  logic [(W << NSTAGE)-1:0] src,
   input  logic [NSTAGE-1:0]        sel,
   output logic [W-1:0]             y
);
   localparam int unsigned GROUP = 1 << NSTAGE;

   // heap layout: node n at [n*W +: W], leaves at GROUP..2*GROUP-1
   logic [2*GROUP*W-1:W] node;

   generate
      for (genvar i = 0; i < GROUP; i++) begin : g_leaf
         assign node[(GROUP+i)*W +: W] = src[i*W +: W];
      end
      for (genvar n = 1; n < GROUP; n++) begin : g_node
         localparam int unsigned DEPTH = $clog2(n + 1) - 1;
         localparam int unsigned BIT   = NSTAGE - 1 - DEPTH;
         assign node[n*W +: W] = sel[BIT] ? node[(2*n+1)*W +: W]
                                          : node[(2*n)*W +: W];
      end
   endgenerate

   assign y = node[W +: W];

endmodule

// File: rtl/gbx_lane_map.sv
module gbx_lane_map #(
   parameter int unsigned LANES = 40
) (
   input  logic [2*LANES-1:0] word,
   input  logic               sdr_mode,
   input  logic               upper_half,
   output logic [LANES-1:0]   d0,
   output logic [LANES-1:0]   d1
);
   logic [LANES-1:0] lo, hi;

   assign lo = word[LANES-1:0];
   assign hi = word[2*LANES-1:LANES];

   always_comb begin
      if (sdr_mode) begin
         d0 = upper_half ? hi : lo;
         d1 = '0;
      end else begin
         d0 = lo;
         d1 = hi;
      end
   end

endmodule

// File: rtl/gbx_tx_ser.sv
module gbx_tx_ser #(
   parameter int unsigned LANES  = 40,
   parameter int unsigned NSTAGE = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              sdr_mode,
   input  logic [NSTAGE:0]                   slot,
   input  logic                              load,
   input  logic                              tx_valid,
   input  logic [(2*LANES << NSTAGE)-1:0]    tx_words,
   output logic [LANES-1:0]                  tx_d0,
   output logic [LANES-1:0]                  tx_d1,
   output logic                              tx_frame
);
   localparam int unsigned W   = 2 * LANES;
   localparam int unsigned BUS = W << NSTAGE;

   logic [BUS-1:0]    hold_q, in_grp, src;
   logic              vld_q;
   logic [NSTAGE-1:0] word_idx;
   logic              upper;
   logic [W-1:0]      cur_word;
   logic [LANES-1:0]  d0_n, d1_n;

   assign in_grp   = tx_valid ? tx_words : '0;
   assign src      = load ? in_grp : hold_q;
   assign word_idx = sdr_mode ? slot[NSTAGE:1] : slot[NSTAGE-1:0];
   assign upper    = sdr_mode & slot[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         vld_q  <= 1'b0;
      end else if (load) begin
         hold_q <= in_grp;
         vld_q  <= tx_valid;
      end
   end

   gbx_mux_tree #(.W(W), .NSTAGE(NSTAGE)) u_tree (
      .src (src),
      .sel (word_idx),
      .y   (cur_word)
   );

   gbx_lane_map #(.LANES(LANES)) u_map (
      .word       (cur_word),
      .sdr_mode   (sdr_mode),
      .upper_half (upper),
      .d0         (d0_n),
      .d1         (d1_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_d0    <= '0;
         tx_d1    <= '0;
         tx_frame <= 1'b0;
      end else begin
         tx_d0    <= d0_n;
         tx_d1    <= d1_n;
         tx_frame <= load && tx_valid;
      end
   end

   // R5
   sdr_d1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdr_mode && $past(sdr_mode)) |-> (tx_d1 == '0));

   // R6
   frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame |=> !tx_frame);

   // R6
   frame_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame |-> $past(load));

   // unused hold while valid flag low: keep vld_q observable
   // R7
   idle_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !vld_q && $past(!load)) |=> (tx_d0 == '0 && tx_d1 == '0));

endmodule

// File: rtl/gbx_rx_deser.sv
module gbx_rx_deser #(
   parameter int unsigned LANES  = 40,
   parameter int unsigned NSTAGE = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              sdr_mode,
   input  logic [LANES-1:0]                  rx_d0,
   input  logic [LANES-1:0]                  rx_d1,
   input  logic                              rx_frame,
   output logic                              rx_valid,
   output logic [(2*LANES << NSTAGE)-1:0]    rx_words
);
   import gbx_pkg::*;

   localparam int unsigned W     = 2 * LANES;
   localparam int unsigned GROUP = 1 << NSTAGE;
   localparam int unsigned BUS   = W * GROUP;
   localparam int unsigned SW    = NSTAGE + 1;

   logic [SW-1:0]     cnt_q, cur_slot, last_slot;
   logic              busy_q, take, last;
   logic [NSTAGE-1:0] word_idx;
   logic              upper;
   logic [BUS-1:0]    acc_q, base, nxt;
   logic [GROUP-1:0]  wr_en;

   assign last_slot = SW'(gbx_slots(gbx_rate_e'(sdr_mode), GROUP) - 1);
   assign cur_slot  = rx_frame ? '0 : cnt_q;
   assign take      = rx_frame | busy_q;
   assign last      = take && (cur_slot == last_slot);
   assign word_idx  = sdr_mode ? cur_slot[NSTAGE:1] : cur_slot[NSTAGE-1:0];
   assign upper     = sdr_mode & cur_slot[0];
   assign base      = rx_frame ? '0 : acc_q;

   generate
      for (genvar i = 0; i < GROUP; i++) begin : g_word
         assign wr_en[i] = take && (word_idx == NSTAGE'(i));
         assign nxt[i*W +: W] =
            !wr_en[i] ? base[i*W +: W] :
            !sdr_mode ? {rx_d1, rx_d0} :
            upper     ? {rx_d0, base[i*W +: LANES]} :
                        {base[i*W+LANES +: LANES], rx_d0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         busy_q   <= 1'b0;
         acc_q    <= '0;
         rx_valid <= 1'b0;
         rx_words <= '0;
      end else begin
         rx_valid <= last;
         if (take) begin
            acc_q <= nxt;
            if (last) begin
               rx_words <= nxt;
               busy_q   <= 1'b0;
               cnt_q    <= '0;
            end else begin
               busy_q   <= 1'b1;
               cnt_q    <= cur_slot + 1'b1;
            end
         end
      end
   end

   // R8
   rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R8
   rx_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(take));

   // R9
   realign_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_frame && !last) |=> (busy_q && cnt_q == SW'(1)));

endmodule

// File: rtl/gbx_d2d_gearbox.sv
module gbx_d2d_gearbox #(
   parameter int unsigned LANES  = 40,
   parameter int unsigned NSTAGE = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              sdr_mode,
   input  logic                              tx_valid,
   input  logic [(2*LANES << NSTAGE)-1:0]    tx_words,
   output logic                              tx_load,
   output logic [LANES-1:0]                  tx_d0,
   output logic [LANES-1:0]                  tx_d1,
   output logic                              tx_frame,
   input  logic [LANES-1:0]                  rx_d0,
   input  logic [LANES-1:0]                  rx_d1,
   input  logic                              rx_frame,
   output logic                              rx_valid,
   output logic [(2*LANES << NSTAGE)-1:0]    rx_words
);
   generate
      if (NSTAGE < 1 || NSTAGE > 4) begin : g_bad_stage
         $error("gbx_d2d_gearbox: NSTAGE must be 1..4");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("gbx_d2d_gearbox: LANES must be at least 1");
      end
   endgenerate

   logic [NSTAGE:0] slot;
   logic            load;

   gbx_phase_ctr #(.NSTAGE(NSTAGE)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .sdr_mode (sdr_mode),
      .slot     (slot),
      .load     (load)
   );

   gbx_tx_ser #(.LANES(LANES), .NSTAGE(NSTAGE)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sdr_mode (sdr_mode),
      .slot     (slot),
      .load     (load),
      .tx_valid (tx_valid),
      .tx_words (tx_words),
      .tx_d0    (tx_d0),
      .tx_d1    (tx_d1),
      .tx_frame (tx_frame)
   );

   gbx_rx_deser #(.LANES(LANES), .NSTAGE(NSTAGE)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sdr_mode (sdr_mode),
      .rx_d0    (rx_d0),
      .rx_d1    (rx_d1),
      .rx_frame (rx_frame),
      .rx_valid (rx_valid),
      .rx_words (rx_words)
   );

   assign tx_load = load;

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!tx_frame && !rx_valid));

endmodule

// File: tb/sim_gbx_d2d_gearbox.sv
module sim_gbx_d2d_gearbox;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 40;
   localparam int W = 80;
   localparam int BUS = 320;

   logic clk = 1'b0;
   logic rst_n, sdr_mode, tx_valid, tx_load, tx_frame, rx_valid;
   logic [BUS-1:0] tx_words, rx_words;
   logic [LANES-1:0] tx_d0, tx_d1, rx_d0, rx_d1;
   logic rx_frame;
   logic loop_en;
   logic [LANES-1:0] bd0, bd1;
   logic bfrm;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   logic [BUS-1:0] expq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rx_d0    = loop_en ? tx_d0 : bd0;
   assign rx_d1    = loop_en ? tx_d1 : bd1;
   assign rx_frame = loop_en ? tx_frame : bfrm;

   gbx_d2d_gearbox u0 (
      .clk(clk), .rst_n(rst_n), .sdr_mode(sdr_mode),
      .tx_valid(tx_valid), .tx_words(tx_words), .tx_load(tx_load),
      .tx_d0(tx_d0), .tx_d1(tx_d1), .tx_frame(tx_frame),
      .rx_d0(rx_d0), .rx_d1(rx_d1), .rx_frame(rx_frame),
      .rx_valid(rx_valid), .rx_words(rx_words)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [BUS-1:0] act, input logic [BUS-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [BUS-1:0] pattern(input int seed);
      logic [BUS-1:0] v;
      for (int j = 0; j < BUS/32; j++)
         v[j*32 +: 32] = (seed * 32'h9E3779B1) ^ (j * 32'h01000193) ^ 32'h5A5A0F0F;
      return v;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R8 R9 unexpected rx_valid", rx_words, '0);
         end else begin
            logic [BUS-1:0] e;
            e = expq.pop_front();
            chk(rx_words == e, "R8 rebuilt group", rx_words, e);
         end
      end
   end

   task automatic wait_load();
      while (!tx_load) @(negedge clk);
   endtask

   task automatic send(input logic [BUS-1:0] w, input bit vld, input bit check_pads);
      int slots;
      wait_load();
      tx_valid = vld;
      tx_words = w;
      if (vld && loop_en) expq.push_back(w);
      @(negedge clk);
      tx_valid = 1'b0;
      tx_words = '0;
      if (check_pads) begin
         slots = sdr_mode ? 8 : 4;
         for (int s = 0; s < slots; s++) begin
            logic [W-1:0] ew;
            logic [LANES-1:0] e0, e1;
            int k;
            k  = sdr_mode ? s / 2 : s;
            ew = vld ? w[k*W +: W] : '0;
            if (sdr_mode) begin
               e0 = (s % 2 == 1) ? ew[79:40] : ew[39:0];
               e1 = '0;
               chk(tx_d0 == e0 && tx_d1 == e1, vld ? "R5 R3 single-rate slot" : "R7 idle lanes",
                   {tx_d1, tx_d0}, {e1, e0});
            end else begin
               e0 = ew[39:0];
               e1 = ew[79:40];
               chk(tx_d0 == e0 && tx_d1 == e1, vld ? "R4 R3 double-rate slot" : "R7 idle lanes",
                   {tx_d1, tx_d0}, {e1, e0});
            end
            chk(tx_frame == (vld && s == 0), "R6 frame marker", BUS'(tx_frame), BUS'(vld && s == 0));
            if (s < slots - 1) @(negedge clk);
         end
         @(negedge clk);
         chk(rx_valid == vld, "R8 rx_valid timing", BUS'(rx_valid), BUS'(vld));
      end
   endtask

   task automatic cadence(input int expect_n);
      int n;
      wait_load();
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tx_load);
      chk(n == expect_n, "R2 load period", BUS'(n), BUS'(expect_n));
   endtask

   initial begin
      #(CLK_PERIOD * 60000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [BUS-1:0] b;
      rst_n = 1'b0; sdr_mode = 1'b0; tx_valid = 1'b0; tx_words = '0;
      loop_en = 1'b1; bd0 = '0; bd1 = '0; bfrm = 1'b0;
      repeat (3) @(negedge clk);
      chk(tx_d0 == '0 && tx_d1 == '0 && !tx_frame && !rx_valid, "R1 reset outputs",
          {tx_d1, tx_d0}, '0);
      rst_n = 1'b1;
      #1;
      chk(tx_load == 1'b1, "R1 first load after reset", BUS'(tx_load), BUS'(1));
      chk(tx_d0 == '0 && tx_d1 == '0 && !tx_frame && !rx_valid, "R1 quiet after reset",
          {tx_d1, tx_d0}, '0);

      // double-rate
      cadence(4);
      send(pattern(1), 1'b1, 1'b1);
      send({BUS{1'b1}}, 1'b1, 1'b1);
      for (int g = 0; g < 4; g++) send(pattern(10 + g), 1'b1, 1'b0);
      send(pattern(99), 1'b0, 1'b1);
      repeat (10) @(negedge clk);

      // single-rate
      wait_load();
      sdr_mode = 1'b1;
      cadence(8);
      send(pattern(2), 1'b1, 1'b1);
      for (int g = 0; g < 2; g++) send(pattern(20 + g), 1'b1, 1'b0);
      send(pattern(98), 1'b0, 1'b1);
      repeat (20) @(negedge clk);
      wait_load();
      sdr_mode = 1'b0;
      cadence(4);
      repeat (10) @(negedge clk);

      // R9 receive realignment with injected lanes
      loop_en = 1'b0;
      b = pattern(7);
      @(negedge clk);
      bfrm = 1'b1; {bd1, bd0} = pattern(5)[W-1:0];
      @(negedge clk);
      bfrm = 1'b0; {bd1, bd0} = pattern(5)[2*W-1:W];
      @(negedge clk);
      expq.push_back(b);
      for (int k = 0; k < 4; k++) begin
         bfrm = (k == 0);
         {bd1, bd0} = b[k*W +: W];
         @(negedge clk);
      end
      bfrm = 1'b0; bd0 = '0; bd1 = '0;
      chk(rx_valid == 1'b1, "R9 realigned group strobe", BUS'(rx_valid), BUS'(1));
      repeat (8) @(negedge clk);
      loop_en = 1'b1;

      repeat (20) @(negedge clk);
      chk(expq.size() == 0, "R8 every sent group delivered", BUS'(expq.size()), '0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule